// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits in front of a byte-wide boot-block flash array. It watches bus write cycles for command bytes and decides what later read cycles return: the array contents, a status byte, or the two identification codes. Two-write instructions (block erase, byte program) are sequenced here. When the second write arrives, the target address and data are handed to a behavioural program/erase engine. That engine stands in for the analog timing with a cycle counter.

The bus is synchronous. A write is taken on the first clock where chip enable and write enable are both low. A read is active while chip enable and output enable are both low, and read data appears on `dout` two clock edges after the read starts. While the engine is running, every read returns the status byte, whatever mode was selected. During an erase, only the status-read and suspend commands are accepted. The status byte is captured when a read begins and is held until that read ends, so the value does not change partway through a read.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return array contents, the status byte is 0x80, and `dout` is 0x00 whenever no read is active. Array contents survive reset.
- R2: Command 0x70 selects status reads. It is accepted at any time, including while the engine runs.
- R3: Command 0x90 selects identification reads. With address bit 0 low the read returns 0x20. With address bit 0 high it returns 0xF3 when TOP_BOOT=1, or 0xFB otherwise. All other address bits are ignored.
- R4: Command 0xFF selects array reads of the addressed byte.
- R5: Writing 0x20 and then 0xD0 erases the block selected by the address bits above BLK_AW that were given with the 0xD0 write. Every byte of that block becomes 0xFF.
- R6: If the write after 0x20 is not 0xD0, status bits 5 and 4 are set, the engine does not start, and the array is left unchanged.
- R7: Writing 0x40 or 0x10, then a second write, stores the old byte ANDed with the second write's data at that write's address. Neighbouring bytes are unchanged.
- R8: While the engine runs, every read returns the status byte, whatever the selected mode.
- R9: While an erase runs, every command other than 0x70 and 0xB0 is ignored. This includes 0x50 and 0x90.
- R10: Status bit 7 is 1 when ready and 0 when busy. Bit 6 is 1 while an erase is suspended. Bits 5 (erase fail), 4 (program fail) and 3 (supply fault) stay set until command 0x50 clears them. Bits 2..0 read 0.
- R11: Command 0xB0 suspends a running erase, giving status 0xC0. While suspended, mode commands work and setup commands are ignored. Command 0xD0 resumes the erase, which then completes.
- R12: The status byte returned by a read is the value at the cycle the read began. It is held until chip enable or output enable returns high.
- R13: If `vpp_ok` is low or `rp_n` is low during an erase, the erase stops and bit 3 is set. A program that starts with `vpp_ok` low sets bit 3 and writes nothing.
- R14: Erasing the boot block (the highest block if TOP_BOOT=1, otherwise block 0) with `rp_hv` low sets bit 5 without starting. A high `force_fail` at completion sets bit 5 (erase) or bit 4 (program).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Registered read data |
| vpp_ok | input | 1 | Programming supply in range |
| rp_n | input | 1 | Reset pin level, low aborts an erase |
| rp_hv | input | 1 | Reset pin at high voltage, unlocks the boot block |
| force_fail | input | 1 | Test input: mark the finishing operation as failed |

## Verification
The status capture at the start of a read and the engine's busy-to-ready transition can land inside the same read. The bench starts a program, opens a read at once and holds it well past the engine's completion. It expects the busy value 0x00 throughout the hold, and then 0x80 from a fresh read. Suspend and resume commands also arrive while the erase sweep is stepping. After the resume, a read in array mode must still return status, and once the erase completes the final array contents are compared with 0xFF.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    CI_IDLE        = 2'd0,
    CI_ERASE_SETUP = 2'd1,
    CI_PROG_SETUP  = 2'd2
  } ci_state_e;

  typedef enum logic [2:0] {
    ENG_IDLE   = 3'd0,
    ENG_PREAD  = 3'd1,
    ENG_PWRITE = 3'd2,
    ENG_PWAIT  = 3'd3,
    ENG_ERUN   = 3'd4,
    ENG_ESUSP  = 3'd5
  } eng_state_e;

  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_READ_IDENT  = 8'h90;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_CONFIRM     = 8'hD0;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
  localparam logic [7:0] OP_PROG_ALT    = 8'h10;
  localparam logic [7:0] OP_CLEAR       = 8'h50;
  localparam logic [7:0] OP_SUSPEND     = 8'hB0;

  localparam logic [7:0] ID_MAKER       = 8'h20;
  localparam logic [7:0] ID_DEV_TOP     = 8'hF3;
  localparam logic [7:0] ID_DEV_BOTTOM  = 8'hFB;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-before-write, synchronous read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 6,
  parameter int BLK_AW   = 4,
  parameter int PROG_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_prog_i,
  input  logic          start_erase_i,
  input  logic          suspend_req_i,
  input  logic          resume_req_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [7:0]    tgt_data_i,
  input  logic          vpp_ok_i,
  input  logic          rp_n_i,
  input  logic          force_fail_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          busy_o,
  output logic          suspended_o,
  output logic          set_vpp_o,
  output logic          set_pfail_o,
  output logic          set_efail_o
);
  localparam int CW = $clog2(PROG_CYC + 1);
  localparam logic [BLK_AW-1:0] IDX_LAST = {BLK_AW{1'b1}};
  localparam logic [CW-1:0] CNT_LAST = CW'(PROG_CYC - 1);

  eng_state_e        state_q;
  logic [BLK_AW-1:0] idx_q;
  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     a_q;
  logic [7:0]        d_q;
  logic              supply_bad;

  assign supply_bad = !vpp_ok_i || !rp_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ENG_IDLE;
      idx_q       <= '0;
      cnt_q       <= '0;
      a_q         <= '0;
      d_q         <= '0;
      set_vpp_o   <= 1'b0;
      set_pfail_o <= 1'b0;
      set_efail_o <= 1'b0;
    end else begin
      set_vpp_o   <= 1'b0;
      set_pfail_o <= 1'b0;
      set_efail_o <= 1'b0;
      case (state_q)
        ENG_IDLE: begin
          if (start_prog_i) begin
            a_q     <= tgt_addr_i;
            d_q     <= tgt_data_i;
            state_q <= ENG_PREAD;
          end else if (start_erase_i) begin
            a_q     <= tgt_addr_i;
            idx_q   <= '0;
            state_q <= ENG_ERUN;
          end
        end
        ENG_PREAD: begin
          if (!vpp_ok_i) begin
            set_vpp_o <= 1'b1;
            state_q   <= ENG_IDLE;
          end else begin
            state_q <= ENG_PWRITE;
          end
        end
        ENG_PWRITE: begin
          cnt_q   <= '0;
          state_q <= ENG_PWAIT;
        end
        ENG_PWAIT: begin
          if (cnt_q == CNT_LAST) begin
            set_pfail_o <= force_fail_i;
            state_q     <= ENG_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ENG_ERUN: begin
          if (supply_bad) begin
            set_vpp_o <= 1'b1;
            state_q   <= ENG_IDLE;
          end else if (idx_q == IDX_LAST) begin
            set_efail_o <= force_fail_i;
            state_q     <= ENG_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (suspend_req_i) state_q <= ENG_ESUSP;
          end
        end
        ENG_ESUSP: begin
          if (resume_req_i) state_q <= ENG_ERUN;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr_o  = a_q;
    mem_wdata_o = 8'hFF;
    mem_we_o    = 1'b0;
    if (state_q == ENG_PWRITE) begin
      mem_we_o    = 1'b1;
      mem_wdata_o = mem_rdata_i & d_q;
    end else if (state_q == ENG_ERUN) begin
      mem_addr_o = {a_q[AW-1:BLK_AW], idx_q};
      mem_we_o   = !supply_bad;
    end
  end

  assign busy_o      = (state_q != ENG_IDLE) && (state_q != ENG_ESUSP);
  assign suspended_o = (state_q == ENG_ESUSP);

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ENG_IDLE && start_prog_i) |=> busy_o);

  assert_supply_abort_R13: assert property (@(posedge clk) disable iff (rst)
    (state_q == ENG_ERUN && supply_bad) |=> (state_q == ENG_IDLE && set_vpp_o));

  assert_suspend_takes_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ENG_ERUN && suspend_req_i && !supply_bad && idx_q != IDX_LAST)
      |=> suspended_o);

  assert_resume_runs_R11: assert property (@(posedge clk) disable iff (rst)
    (suspended_o && resume_req_i) |=> busy_o);
endmodule

// File: rtl/flash_status.sv
module flash_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       set_vpp_i,
  input  logic       set_pfail_i,
  input  logic       set_efail_i,
  input  logic       busy_i,
  input  logic       suspended_i,
  output logic [7:0] status_o
);
  // err_q[2] erase fail, err_q[1] program fail, err_q[0] supply fault
  logic [2:0] err_q;

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (clr_i ? 3'b000 : err_q) | {set_efail_i, set_pfail_i, set_vpp_i};
  end

  assign status_o = {!busy_i, suspended_i, err_q, 3'b000};

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((err_q & $past(err_q)) == $past(err_q)));

  assert_vpp_sets_R13: assert property (@(posedge clk) disable iff (rst)
    set_vpp_i |=> err_q[0]);

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_vpp_i && !set_pfail_i && !set_efail_i) |=> (err_q == 3'b000));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 6,
  parameter int BLK_AW   = 4,
  parameter int PROG_CYC = 8,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  input  logic          vpp_ok,
  input  logic          rp_n,
  input  logic          rp_hv,
  input  logic          force_fail
);
  localparam int NBB = AW - BLK_AW;
  localparam logic [NBB-1:0] BOOT_BLK = TOP_BOOT ? {NBB{1'b1}} : {NBB{1'b0}};
  localparam logic [7:0] ID_DEV = TOP_BOOT ? ID_DEV_TOP : ID_DEV_BOTTOM;

  // bus strobes
  logic wr_act, wr_q, wr_fire, rd_act, rd_q;
  assign wr_act  = !ce_n && !we_n;
  assign rd_act  = !ce_n && !oe_n;
  assign wr_fire = wr_act && !wr_q;

  // engine / status wiring
  logic          eng_busy, eng_susp, eng_we;
  logic          eng_vpp, eng_pfail, eng_efail;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_wdata, mem_rdata, status;

  // decoder outputs
  rd_mode_e  mode_q, mode_n;
  ci_state_e ci_q, ci_n;
  logic start_prog, start_erase, susp_req, resume_req;
  logic clr_req, abort_seq, boot_reject, is_boot;

  assign is_boot = (addr[AW-1:BLK_AW] == BOOT_BLK);

  always_comb begin
    mode_n      = mode_q;
    ci_n        = ci_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    susp_req    = 1'b0;
    resume_req  = 1'b0;
    clr_req     = 1'b0;
    abort_seq   = 1'b0;
    boot_reject = 1'b0;
    if (wr_fire) begin
      if (eng_busy) begin
        if (din == OP_READ_STATUS) mode_n   = MODE_STATUS;
        if (din == OP_SUSPEND)     susp_req = 1'b1;
      end else begin
        case (ci_q)
          CI_ERASE_SETUP: begin
            ci_n   = CI_IDLE;
            mode_n = MODE_STATUS;
            if (din != OP_CONFIRM)      abort_seq   = 1'b1;
            else if (is_boot && !rp_hv) boot_reject = 1'b1;
            else                        start_erase = 1'b1;
          end
          CI_PROG_SETUP: begin
            ci_n       = CI_IDLE;
            mode_n     = MODE_STATUS;
            start_prog = 1'b1;
          end
          default: begin
            case (din)
              OP_READ_ARRAY:  mode_n  = MODE_ARRAY;
              OP_READ_STATUS: mode_n  = MODE_STATUS;
              OP_READ_IDENT:  mode_n  = MODE_IDENT;
              OP_CLEAR:       clr_req = 1'b1;
              OP_ERASE_SETUP: if (!eng_susp) ci_n = CI_ERASE_SETUP;
              OP_PROG_SETUP,
              OP_PROG_ALT:    if (!eng_susp) ci_n = CI_PROG_SETUP;
              OP_CONFIRM:     if (eng_susp) resume_req = 1'b1;
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_ARRAY;
      ci_q   <= CI_IDLE;
      wr_q   <= 1'b0;
    end else begin
      mode_q <= mode_n;
      ci_q   <= ci_n;
      wr_q   <= wr_act;
    end
  end

  // read path: stage 1 captures selection and status, stage 2 registers dout
  rd_mode_e   sel_q;
  logic       rd1_q, a0_q;
  logic [7:0] snap_q, dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      rd1_q  <= 1'b0;
      a0_q   <= 1'b0;
      sel_q  <= MODE_ARRAY;
      snap_q <= 8'h80;
      dout_q <= 8'h00;
    end else begin
      rd_q  <= rd_act;
      rd1_q <= rd_act;
      a0_q  <= addr[0];
      sel_q <= eng_busy ? MODE_STATUS : mode_q;
      if (rd_act && !rd_q) snap_q <= status;
      if (!rd1_q) dout_q <= 8'h00;
      else begin
        case (sel_q)
          MODE_STATUS: dout_q <= snap_q;
          MODE_IDENT:  dout_q <= a0_q ? ID_DEV : ID_MAKER;
          default:     dout_q <= mem_rdata;
        endcase
      end
    end
  end

  assign dout = dout_q;

  flash_array #(.AW(AW), .DW(8)) u_array (
    .clk   (clk),
    .we    (eng_we),
    .addr  (eng_busy ? eng_addr : addr),
    .wdata (eng_wdata),
    .rdata (mem_rdata)
  );

  flash_pe_engine #(.AW(AW), .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC)) u_engine (
    .clk           (clk),
    .rst           (rst),
    .start_prog_i  (start_prog),
    .start_erase_i (start_erase),
    .suspend_req_i (susp_req),
    .resume_req_i  (resume_req),
    .tgt_addr_i    (addr),
    .tgt_data_i    (din),
    .vpp_ok_i      (vpp_ok),
    .rp_n_i        (rp_n),
    .force_fail_i  (force_fail),
    .mem_rdata_i   (mem_rdata),
    .mem_we_o      (eng_we),
    .mem_addr_o    (eng_addr),
    .mem_wdata_o   (eng_wdata),
    .busy_o        (eng_busy),
    .suspended_o   (eng_susp),
    .set_vpp_o     (eng_vpp),
    .set_pfail_o   (eng_pfail),
    .set_efail_o   (eng_efail)
  );

  flash_status u_status (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (clr_req),
    .set_vpp_i   (eng_vpp),
    .set_pfail_i (eng_pfail | abort_seq),
    .set_efail_i (eng_efail | abort_seq | boot_reject),
    .busy_i      (eng_busy),
    .suspended_i (eng_susp),
    .status_o    (status)
  );

  assert_bad_confirm_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && ci_q == CI_ERASE_SETUP && din != OP_CONFIRM)
      |=> (status[5] && status[4] && !eng_busy));

  assert_no_setup_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && eng_busy) |=> (ci_q == CI_IDLE));

  assert_snap_held_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_act && rd_q) |=> $stable(snap_q));

  assert_idle_dout_R1: assert property (@(posedge clk) disable iff (rst)
    !rd1_q |=> (dout == 8'h00));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, ce_n, oe_n, we_n, vpp_ok, rp_n, rp_hv, force_fail;
  logic [AW-1:0] addr;
  logic [7:0]    din, dout;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       smp_ev;

  flash_cmd_ctrl #(.AW(AW), .BLK_AW(4), .PROG_CYC(8), .TOP_BOOT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .vpp_ok(vpp_ok), .rp_n(rp_n),
    .rp_hv(rp_hv), .force_fail(force_fail)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item and compares at the strobe
  initial forever begin
    @(smp_ev);
    check(tag_q.pop_front(), dout, exp_q.pop_front());
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t, input int hold);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    repeat (3 + hold) @(negedge clk);
    -> smp_ev;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    vpp_ok = 1'b1; rp_n = 1'b1; rp_hv = 1'b0; force_fail = 1'b0;
    idle(3); rst = 1'b0; idle(1);

    check("R1 idle dout", dout, 8'h00);
    wr(0, 8'h70); rd(0, 8'h80, "R1 reset status", 0);

    wr(0, 8'h90);
    rd(6'h00, 8'h20, "R3 maker code", 0);
    rd(6'h2B, 8'hF3, "R3 device code", 0);
    rd(6'h3E, 8'h20, "R3 upper bits ignored", 0);

    wr(0, 8'h20); wr(6'h13, 8'hD0);
    rd(6'h15, 8'h00, "R8 busy status", 0);
    idle(30);
    rd(6'h15, 8'h80, "R10 ready after erase", 0);
    wr(0, 8'hFF);
    rd(6'h15, 8'hFF, "R5 erased byte", 0);
    rd(6'h1A, 8'hFF, "R5 erased other byte", 0);

    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    rd(6'h15, 8'hFF, "R1 array mode after reset", 0);

    wr(0, 8'h40); wr(6'h15, 8'hA5); idle(20);
    rd(6'h15, 8'h80, "R7 program done", 0);
    wr(0, 8'hFF); rd(6'h15, 8'hA5, "R4 R7 programmed byte", 0);
    wr(0, 8'h10); wr(6'h15, 8'h3C); idle(20);
    wr(0, 8'hFF);
    rd(6'h15, 8'h24, "R7 and of old and new", 0);
    rd(6'h16, 8'hFF, "R7 neighbour unchanged", 0);

    wr(0, 8'h20); wr(6'h15, 8'h33);
    rd(6'h15, 8'hB0, "R6 abort bits", 0);
    wr(0, 8'hFF); rd(6'h15, 8'h24, "R6 array unchanged", 0);

    wr(0, 8'h20); wr(6'h10, 8'hD0);
    wr(0, 8'h50); wr(0, 8'h90); idle(30);
    rd(6'h01, 8'hB0, "R9 commands ignored while erasing", 0);
    wr(0, 8'h50); rd(0, 8'h80, "R10 clear", 0);

    wr(0, 8'h40); wr(6'h15, 8'h00); idle(20);
    wr(0, 8'h20); wr(6'h10, 8'hD0); wr(0, 8'hB0); idle(2);
    rd(0, 8'hC0, "R11 suspended", 0);
    wr(0, 8'hFF); wr(0, 8'h20); wr(0, 8'hD0);
    rd(6'h15, 8'h00, "R8 status in array mode while busy", 0);
    idle(30);
    rd(6'h15, 8'hFF, "R11 erase finished after resume", 0);

    wr(0, 8'h20); wr(6'h10, 8'hD0); wr(0, 8'hB0); wr(0, 8'hFF);
    wr(0, 8'hD0); wr(0, 8'h70); idle(30);
    rd(6'h15, 8'h80, "R2 status command while busy", 0);

    wr(0, 8'h20); wr(6'h10, 8'hD0);
    @(negedge clk); vpp_ok = 1'b0; idle(2); vpp_ok = 1'b1; idle(20);
    rd(0, 8'h88, "R13 supply abort", 0);
    wr(0, 8'h50);
    wr(0, 8'h20); wr(6'h10, 8'hD0);
    @(negedge clk); rp_n = 1'b0; idle(2); rp_n = 1'b1; idle(20);
    rd(0, 8'h88, "R13 reset pin abort", 0);
    wr(0, 8'h50);
    wr(0, 8'h20); wr(6'h10, 8'hD0); idle(30);
    vpp_ok = 1'b0;
    wr(0, 8'h40); wr(6'h16, 8'h00); idle(5); vpp_ok = 1'b1; idle(10);
    rd(0, 8'h88, "R13 program low supply", 0);
    wr(0, 8'hFF); rd(6'h16, 8'hFF, "R13 no write", 0);
    wr(0, 8'h50);

    wr(0, 8'h20); wr(6'h30, 8'hD0);
    rd(0, 8'hA0, "R14 boot block refused", 0);
    wr(0, 8'h50);
    rp_hv = 1'b1;
    wr(0, 8'h20); wr(6'h30, 8'hD0); idle(30);
    rp_hv = 1'b0;
    rd(0, 8'h80, "R14 boot erase ok", 0);
    wr(0, 8'hFF); rd(6'h31, 8'hFF, "R14 boot block erased", 0);

    force_fail = 1'b1;
    wr(0, 8'h40); wr(6'h31, 8'h0F); idle(20);
    rd(0, 8'h90, "R14 forced program fail", 0);
    wr(0, 8'h50);
    wr(0, 8'h20); wr(6'h20, 8'hD0); idle(30);
    rd(0, 8'hA0, "R14 forced erase fail", 0);
    force_fail = 1'b0;
    wr(0, 8'h50);

    wr(0, 8'h40); wr(6'h32, 8'hF0);
    rd(0, 8'h00, "R12 held busy snapshot", 20);
    rd(0, 8'h80, "R12 refreshed snapshot", 0);

    idle(2);
    check("R1 idle dout at end", dout, 8'h00);
    finish_run();
  end
endmodule